// File: doc/BRIEF.md
# ADC Overload Level Detector

This block watches the stereo sample stream leaving an audio ADC's decimation chain and raises one overload flag when either channel gets too close to digital full scale. Each sample pair arrives with a one-cycle strobe at the sampling rate. The block takes the magnitude of each two's-complement sample and compares it with a fixed level at seven eighths of full scale, which is about 1.16 dB below maximum swing. Any sample above that level sets the flag.

Once the flag is set, it stays high for a minimum hold time counted in sample periods, 512 by default. Each new offending sample reloads the hold time to its full value, so a run of loud material keeps the flag up without a break. The hold counter advances only on sample strobes, so the hold time tracks the sampling rate and does not depend on the system clock frequency. Recording software or a level meter can poll the flag to adjust the recording level.

Top module: `adc_clip_monitor`

## Requirements
- R1: The synchronous active-low reset clears the hold time. After reset the flag is low and stays low until a new offending sample arrives, even if a hold was running when reset was applied.
- R2: When a strobed sample pair contains an offending sample, the flag is high on the clock cycle after that strobe edge.
- R3: A sample is offending only when its magnitude is strictly greater than 7·2^(W-4), where W is the sample width. A magnitude equal to that value does not set the flag.
- R4: A negative sample is judged by its absolute value, so -(7·2^(W-4)+1) is offending and -(7·2^(W-4)) is not.
- R5: The most negative code, -2^(W-1), is treated as the maximum positive magnitude and is offending.
- R6: An offending sample on the left channel alone, or on the right channel alone, sets the single shared flag.
- R7: After the last offending strobe, the flag stays high through the next HOLD_SAMPLES-1 clean strobes. It falls on the clock cycle after the HOLD_SAMPLES-th clean strobe.
- R8: An offending sample that arrives while the flag is already high restarts the hold from its full value, measured from that sample.
- R9: Sample values presented while the strobe is low are ignored. They neither set the flag nor restart the hold.
- R10: Without strobes the hold does not advance, so a raised flag stays high for any number of clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample pair |
| smp_left | input | W | Left sample, two's complement |
| smp_right | input | W | Right sample, two's complement |
| ovl_flag | output | 1 | Registered overload flag shared by both channels |

## Verification
On every cycle, the assertions check four things: that the flag clears under reset, that an offending strobe raises the flag on the next edge, that the flag never rises without such a strobe, and that the flag holds steady between strobes. A counter in the checker also tracks clean strobes, so the exact hold length and the restart of the hold are checked continuously. Only the directed scenarios show the threshold boundary at its exact code, and only they show that the most negative code and single-channel hits each fall on the correct side of the threshold. They also show that a reset in the middle of a hold drops the flag for good.

// File: rtl/clipmon_pkg.sv
// Shared helpers for the overload detector.
// Assumes the sample width is at least 4 bits.
package clipmon_pkg;

    // Overload level: seven eighths of full scale for a w-bit signed sample
    function automatic longint unsigned clip_level(input int w);
        return longint'(7) << (w - 4);
    endfunction

endpackage

// File: rtl/clipmon_mag.sv
// Absolute value of a two's-complement sample.
// The most negative code saturates to the largest positive magnitude,
// so the result fits in W-1 bits.
module clipmon_mag #(
    parameter int W = 24
) (
    input  logic [W-1:0] sample,
    output logic [W-2:0] mag
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] negated;

    // Form the magnitude with saturation on the one code that has no positive twin
    always_comb begin
        negated = -sample;
        if (!sample[W-1])
            mag = sample[W-2:0];
        else if (sample == MOST_NEG)
            mag = {(W-1){1'b1}};
        else
            mag = negated[W-2:0];
    end
endmodule

// File: rtl/clipmon_cmp.sv
// Compares a magnitude against the fixed overload level.
// The comparison is strictly greater-than.
module clipmon_cmp #(
    parameter int W = 24
) (
    input  logic [W-2:0] mag,
    output logic         over
);
    import clipmon_pkg::*;

    localparam longint unsigned LEVEL_L = clip_level(W);
    localparam logic [W-2:0]    LEVEL   = LEVEL_L[W-2:0];

    // Flag magnitudes above the level
    always_comb over = (mag > LEVEL);
endmodule

// File: rtl/clipmon_hold.sv
// Retriggerable hold timer driving the registered overload flag.
// It loads HOLD on an offending strobe, counts down on clean strobes,
// and ignores cycles without a strobe.
module clipmon_hold #(
    parameter int HOLD = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hit,
    output logic flag
);
    localparam int           CW       = $clog2(HOLD + 1);
    localparam logic [CW-1:0] HOLD_CW = CW'(HOLD);

    logic [CW-1:0] remain;
    logic [CW-1:0] remain_nxt;

    // Next hold count: reload on a hit, decrement on a clean strobe
    always_comb begin
        remain_nxt = remain;
        if (tick) begin
            if (hit)
                remain_nxt = HOLD_CW;
            else if (remain != '0)
                remain_nxt = remain - CW'(1);
        end
    end

    // Register the count and the flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            flag   <= 1'b0;
        end else begin
            remain <= remain_nxt;
            flag   <= (remain_nxt != '0);
        end
    end
endmodule

// File: rtl/adc_clip_monitor.sv
// Stereo ADC overload detector: one flag for both channels, raised when
// either magnitude exceeds 7/8 of full scale and held for HOLD_SAMPLES
// sample periods after the last offending sample.
// Assumes smp_valid is a single-cycle strobe per sample pair.
module adc_clip_monitor #(
    parameter int W            = 24,
    parameter int HOLD_SAMPLES = 512
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_valid,
    input  logic [W-1:0] smp_left,
    input  logic [W-1:0] smp_right,
    output logic         ovl_flag
);
    localparam int NCH = 2;

    logic [W-1:0] chan_smp [NCH];
    logic [W-2:0] chan_mag [NCH];
    logic [NCH-1:0] chan_over;
    logic any_over;

    // Collect channels into an array for the per-channel path
    always_comb begin
        chan_smp[0] = smp_left;
        chan_smp[1] = smp_right;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        clipmon_mag #(.W(W)) u_mag (
            .sample (chan_smp[c]),
            .mag    (chan_mag[c])
        );
        clipmon_cmp #(.W(W)) u_cmp (
            .mag    (chan_mag[c]),
            .over   (chan_over[c])
        );
    end

    // Either channel counts as an overload
    always_comb any_over = |chan_over;

    clipmon_hold #(.HOLD(HOLD_SAMPLES)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (smp_valid),
        .hit   (any_over),
        .flag  (ovl_flag)
    );
endmodule

// File: rtl/clipmon_checker.sv
// Property checker for adc_clip_monitor. The offending condition is
// re-derived from the port values with signed compares, and the hold
// length is tracked with a local strobe counter.
module clipmon_checker #(
    parameter int W    = 24,
    parameter int HOLD = 512
) (
    input logic         clk,
    input logic         rst_n,
    input logic         smp_valid,
    input logic [W-1:0] smp_left,
    input logic [W-1:0] smp_right,
    input logic         ovl_flag
);
    import clipmon_pkg::*;

    localparam longint LVL = longint'(clip_level(W));

    logic hit_l, hit_r, hit;
    logic armed;
    int   clean;

    // Offending sample test from the ports
    always_comb begin
        hit_l = ($signed(smp_left)  > LVL) || ($signed(smp_left)  < -LVL);
        hit_r = ($signed(smp_right) > LVL) || ($signed(smp_right) < -LVL);
        hit   = smp_valid && (hit_l || hit_r);
    end

    // Count clean strobes since the last offending strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            clean <= 0;
        end else if (hit) begin
            armed <= 1'b1;
            clean <= 0;
        end else if (smp_valid && armed && clean < HOLD) begin
            clean <= clean + 1;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> !ovl_flag);

    assert_hit_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> ovl_flag);

    assert_rise_needs_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovl_flag) |-> $past(hit));

    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(ovl_flag));

    assert_hold_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && clean < HOLD) |-> ovl_flag);

    assert_hold_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && clean == HOLD) |-> !ovl_flag);
endmodule

bind adc_clip_monitor clipmon_checker #(.W(W), .HOLD(HOLD_SAMPLES)) u_clipmon_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_left  (smp_left),
    .smp_right (smp_right),
    .ovl_flag  (ovl_flag)
);

// File: tb/adc_clip_monitor_bench.sv
module adc_clip_monitor_bench;
    localparam int W    = 24;
    localparam int HOLD = 512;
    localparam logic signed [W-1:0] LVL  = W'(7 * (1 << (W - 4)));
    localparam logic signed [W-1:0] MNEG = {1'b1, {(W-1){1'b0}}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic [W-1:0] smp_left = '0;
    logic [W-1:0] smp_right = '0;
    logic ovl_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    adc_clip_monitor #(.W(W), .HOLD_SAMPLES(HOLD)) u_adc_clip_monitor (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smp_left(smp_left), .smp_right(smp_right), .ovl_flag(ovl_flag)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: flag=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One strobed pair; returns at the negedge after the strobe edge
    task automatic strobe(input logic [W-1:0] l, input logic [W-1:0] r);
        @(negedge clk);
        smp_valid = 1'b1; smp_left = l; smp_right = r;
        @(negedge clk);
        smp_valid = 1'b0; smp_left = '0; smp_right = '0;
    endtask

    // n clean strobes with idle cycles between them; reports whether flag stayed high
    task automatic clean_strobes(input int n, output bit stayed);
        stayed = 1'b1;
        for (int i = 0; i < n; i++) begin
            strobe('0, '0);
            if (ovl_flag !== 1'b1) stayed = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 reset state", ovl_flag, 1'b0);
    endtask

    task automatic t_threshold();
        do_reset();
        strobe(LVL, LVL);
        check("R3 equal to level", ovl_flag, 1'b0);
        strobe(-LVL, -LVL);
        check("R4 negative equal to level", ovl_flag, 1'b0);
        strobe(LVL + 1, '0);
        check("R2 R3 above level sets next cycle", ovl_flag, 1'b1);
    endtask

    task automatic t_negative();
        do_reset();
        strobe(-(LVL + 1), '0);
        check("R4 negative above level", ovl_flag, 1'b1);
        do_reset();
        strobe(MNEG, '0);
        check("R5 most negative code", ovl_flag, 1'b1);
    endtask

    task automatic t_channels();
        do_reset();
        strobe('0, LVL + 1);
        check("R6 right only", ovl_flag, 1'b1);
        do_reset();
        strobe(W'(-1), '0);
        check("R6 small left only stays low", ovl_flag, 1'b0);
        strobe(MNEG, '0);
        check("R6 left only", ovl_flag, 1'b1);
    endtask

    task automatic t_hold_length();
        bit stayed;
        do_reset();
        strobe(LVL + 5, '0);
        clean_strobes(HOLD - 1, stayed);
        check("R7 high through HOLD-1 clean strobes", stayed, 1'b1);
        strobe('0, '0);
        check("R7 low after HOLD clean strobes", ovl_flag, 1'b0);
    endtask

    task automatic t_retrigger();
        bit stayed;
        do_reset();
        strobe('0, -(LVL + 9));
        clean_strobes(300, stayed);
        strobe(LVL + 2, '0);
        clean_strobes(HOLD - 1, stayed);
        check("R8 restarted hold still high", stayed, 1'b1);
        strobe('0, '0);
        check("R8 restarted hold ends", ovl_flag, 1'b0);
    endtask

    task automatic t_ignore_and_idle();
        bit stayed;
        do_reset();
        @(negedge clk);
        smp_left = MNEG; smp_right = MNEG;
        repeat (5) @(negedge clk);
        smp_left = '0; smp_right = '0;
        check("R9 unstrobed samples ignored", ovl_flag, 1'b0);
        strobe(MNEG, '0);
        clean_strobes(HOLD - 2, stayed);
        @(negedge clk);
        smp_left = MNEG;
        repeat (3000) @(negedge clk);
        smp_left = '0;
        check("R10 no strobes keeps flag", ovl_flag, 1'b1);
        strobe('0, '0);
        check("R9 unstrobed value did not restart hold", ovl_flag, 1'b1);
        strobe('0, '0);
        check("R9 hold ends on schedule", ovl_flag, 1'b0);
    endtask

    task automatic t_reset_mid_hold();
        bit stayed;
        do_reset();
        strobe(LVL + 1, '0);
        clean_strobes(10, stayed);
        do_reset();
        check("R1 reset drops flag", ovl_flag, 1'b0);
        clean_strobes(3, stayed);
        check("R1 flag stays low after reset", ovl_flag, 1'b0);
    endtask

    initial begin
        t_reset_state();
        t_threshold();
        t_negative();
        t_channels();
        t_hold_length();
        t_retrigger();
        t_ignore_and_idle();
        t_reset_mid_hold();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 200000 && !done; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule